// File: doc/BRIEF.md
# Dual-clause MDIO management master

This block drives a management data bus towards one or more PHYs. It supports both the short frame format (Clause 22) and the extended, indirect-addressed format (Clause 45). Software sees two 32-bit words through a plain write/read port. The command word holds the opcode, the port address, the register or device address, the 16-bit data/address field and the busy and fail flags. The configuration word selects the frame format, sets the MDC divider and can keep MDC running all the time.

To run a transaction, software writes a command word with the busy bit set. The block serialises a full frame on the MDIO pad (output, output-enable, input) and times it with MDC. The frame is a preamble, a start code, the opcode as written, both addresses, the turnaround and the data. On a read, the block releases the line for the turnaround and data bits and stores the captured word in the data field. When the frame ends, busy clears. A failed read turnaround sets the fail flag. An extended-format access takes two commands: an address cycle with the register number in the data field, then the read or write opcode to the same port and device.

Top module: `mdio_master`

## Requirements
- R1: After reset both words read as zero, MDC is low and the MDIO output-enable is low.
- R2: The configuration word is at register address 1. Bit 0 selects the frame format (1 = Clause 22, 0 = Clause 45), bits 11:4 are the 8-bit MDC divider and bit 13 enables free-running MDC. All other bits read as zero.
- R3: The command word is at register address 0. Its layout is data in bits 15:0, register/device address in 20:16, port address in 25:21, opcode in 27:26, fail in bit 28 and busy in bit 29. Bits 31:30 read zero. Writing it with bit 29 set while idle starts a frame: busy reads 1 in the following cycle and stays 1 until the frame ends, then reads 0.
- R4: Every frame is 64 bits, sent MSB first, in this order: 32 ones, a start code (01 for Clause 22, 00 for Clause 45), the 2-bit opcode unchanged, the 5-bit port address, the 5-bit register/device address, 2 turnaround bits and 16 data bits. MDIO output changes only on MDC falling edges.
- R5: In a non-read frame the output-enable stays high for all 64 bits, the turnaround is sent as 1 then 0, and the data field is sent. Afterwards the command word keeps its written data.
- R6: Reads are opcode 2 in Clause 22, and opcodes 2 and 3 in Clause 45. In a read, the output-enable is low from the first turnaround bit to the end of the frame. MDIO is sampled on MDC rising edges, and the 16 data bits replace the data field.
- R7: If the PHY leaves the second turnaround bit of a read high, fail reads 1 when busy clears and the data field keeps its written value.
- R8: Writing an all-zero command clears busy and fail, even mid-frame. It also drops the output-enable and, without free-run, stops MDC low.
- R9: Each MDC half-period lasts divider + 1 system clocks.
- R10: Without free-run, MDC stays low while idle. With free-run, MDC toggles while idle too.
- R11: Clause 45 opcodes 0 (address) and 1 (write) drive the data field like a write. Opcode 2 (read with post-increment) returns data exactly like opcode 3.
- R12: A nonzero command write while busy is ignored: the running frame and the stored fields are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 command, 1 configuration |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output-enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The assertions assume three things. The configuration word is not rewritten while a frame is running. Only one command is issued at a time. The PHY changes MDIO input only around MDC falling edges, so that the value is settled at the rising edge where the block samples it. The stimulus writes configuration only between frames and polls busy before it issues the next command. The PHY model in the bench updates the line on each MDC falling edge, and leaves it pulled high whenever it is not answering a read.

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FL = PRE_LEN + 32;
  localparam int BW = $clog2(FL);
  localparam logic [BW-1:0] OE_OFF = BW'(PRE_LEN + 13);
  localparam logic [BW-1:0] TA_2ND = BW'(PRE_LEN + 15);
  localparam logic [BW-1:0] DAT_0  = BW'(PRE_LEN + 16);
  localparam logic [BW-1:0] LAST   = BW'(FL - 1);

  logic          cfg_c22, cfg_free;
  logic [7:0]    cfg_div;
  logic [1:0]    c_op;
  logic [4:0]    c_phy, c_reg;
  logic [15:0]   c_data;
  logic          busy, fail;
  logic          live, rd, ta_bad, oe_r;
  logic [BW-1:0] bitn;
  logic [FL-1:0] sr;
  logic [15:0]   shin;
  logic [7:0]    cnt;

  wire run    = cfg_free | busy;
  wire tick   = run && (cnt >= cfg_div);
  wire rise   = tick && !mdc;
  wire fall   = tick && mdc;
  wire wr_cmd = reg_wr && !reg_addr;
  wire wr_cfg = reg_wr && reg_addr;
  wire zero   = wr_cmd && (reg_wdata == 32'd0);
  wire rd_w   = cfg_c22 ? (reg_wdata[27:26] == 2'd2) : reg_wdata[27];
  wire [FL-1:0] frame_w = {{PRE_LEN{1'b1}}, 1'b0, cfg_c22, reg_wdata[27:16],
                           rd_w ? 2'b11 : 2'b10, rd_w ? 16'hFFFF : reg_wdata[15:0]};
  wire unused_bits = ^{reg_wdata[31:30], reg_wdata[28]};

  assign reg_rdata = reg_addr ? {18'd0, cfg_free, 1'b0, cfg_div, 3'd0, cfg_c22}
                              : {2'd0, busy, fail, c_op, c_phy, c_reg, c_data};
  assign mdio_o  = sr[FL-1];
  assign mdio_oe = oe_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_c22 <= 1'b0; cfg_free <= 1'b0; cfg_div <= 8'd0;
    end else if (wr_cfg) begin
      cfg_c22 <= reg_wdata[0]; cfg_div <= reg_wdata[11:4]; cfg_free <= reg_wdata[13];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= 8'd0; mdc <= 1'b0;
    end else if (!run) begin
      cnt <= 8'd0; mdc <= 1'b0;
    end else if (tick) begin
      cnt <= 8'd0; mdc <= ~mdc;
    end else
      cnt <= cnt + 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_op <= '0; c_phy <= '0; c_reg <= '0; c_data <= '0;
      busy <= 1'b0; fail <= 1'b0; live <= 1'b0; rd <= 1'b0; ta_bad <= 1'b0;
      oe_r <= 1'b0; bitn <= '0; sr <= '1; shin <= '0;
    end else if (zero) begin
      c_op <= '0; c_phy <= '0; c_reg <= '0; c_data <= '0;
      busy <= 1'b0; fail <= 1'b0; live <= 1'b0; oe_r <= 1'b0;
    end else if (wr_cmd && !busy) begin
      c_op <= reg_wdata[27:26]; c_phy <= reg_wdata[25:21];
      c_reg <= reg_wdata[20:16]; c_data <= reg_wdata[15:0];
      fail <= 1'b0;
      if (reg_wdata[29]) begin
        busy <= 1'b1; sr <= frame_w; rd <= rd_w; ta_bad <= 1'b0;
        bitn <= '0; live <= !run; oe_r <= !run;
      end
    end else if (busy && !live) begin
      if (fall) begin
        live <= 1'b1; oe_r <= 1'b1;
      end
    end else if (busy) begin
      if (rise && rd) begin
        if (bitn == TA_2ND) ta_bad <= mdio_i;
        if (bitn >= DAT_0) shin <= {shin[14:0], mdio_i};
      end
      if (fall) begin
        if (bitn == LAST) begin
          busy <= 1'b0; live <= 1'b0; oe_r <= 1'b0;
          if (rd) begin
            if (ta_bad) fail <= 1'b1;
            else c_data <= shin;
          end
        end else begin
          sr <= {sr[FL-2:0], 1'b1};
          bitn <= bitn + 1'b1;
          if (rd && bitn == OE_OFF) oe_r <= 1'b0;
        end
      end
    end

  // R4
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(live) && !$stable(mdio_o)) |-> (!mdc && $past(mdc)));
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && live && rd && bitn > OE_OFF) |-> !mdio_oe);
  // R7
  fail_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $fell(busy));
  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (!busy && !fail && !mdio_oe));
  // R10
  mdc_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_free && !busy) |=> !mdc);
  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd && !zero && !(fall && bitn == LAST)) |=> (busy && $stable(c_phy) && $stable(c_op)));
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int nchk = 0, errs = 0;
  logic [63:0] qw[$], qo[$];
  logic phy_ta = 1'b0;
  logic [15:0] phy_data = '0;

  always #5 clk = ~clk;

  mdio_master i_mdio_master (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rdr(input logic a, output logic [31:0] q);
    reg_addr = a; #1 q = reg_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] q);
    do begin @(negedge clk); rdr(1'b0, q); end while (q[29]);
  endtask

  function automatic logic [63:0] exp_wire(input logic c22, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
      input logic isrd, input logic ta, input logic [15:0] pd);
    return {32'hFFFFFFFF, 1'b0, c22, op, phy, rg, isrd ? {1'b1, ta} : 2'b10, isrd ? pd : d};
  endfunction

  task automatic run_cmd(input logic c22, input logic [1:0] op, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] d, input logic ta, input logic [15:0] pd,
      input string tag);
    logic [31:0] q;
    logic isrd;
    isrd = c22 ? (op == 2'd2) : op[1];
    phy_ta = ta; phy_data = pd;
    qw.push_back(exp_wire(c22, op, phy, rg, d, isrd, ta, pd));
    qo.push_back(isrd ? {{46{1'b1}}, 18'd0} : {64{1'b1}});
    wr(1'b0, {2'b00, 1'b1, 1'b0, op, phy, rg, d});
    rdr(1'b0, q);
    chk("R3 busy set after start", {63'd0, q[29]}, 64'd1);
    wait_idle(q);
    chk(tag, {32'd0, q}, {32'd0, 2'b00, 1'b0, isrd && ta, op, phy, rg,
                          (isrd && !ta) ? pd : d});
  endtask

  // monitor: PHY model and scoreboard
  initial begin
    logic [63:0] w, o, ew, eo;
    logic isrd;
    forever begin
      @(posedge mdio_oe);
      isrd = 1'b0;
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        w[63-k] = mdio_oe ? mdio_o : mdio_i;
        o[63-k] = mdio_oe;
        if (k == 35) isrd = w[30] ? (w[29:28] == 2'b10) : w[29];
        @(negedge mdc);
        if (isrd && k + 1 == 47) mdio_i = phy_ta;
        else if (isrd && k + 1 >= 48 && k + 1 <= 63) mdio_i = phy_data[62-k];
        else mdio_i = 1'b1;
      end
      if (qw.size() == 0) begin
        chk("R4 unexpected frame", 64'd1, 64'd0);
      end else begin
        ew = qw.pop_front(); eo = qo.pop_front();
        chk("R4 R5 R11 wire frame", w, ew);
        chk("R6 output-enable pattern", o, eo);
      end
    end
  end

  initial begin
    #1_000_000;
    errs++; nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int bad, tog;
    logic pm;
    time t1, t2, t3;
    repeat (3) @(negedge clk);
    rdr(1'b0, q); chk("R1 command reset", {32'd0, q}, 64'd0);
    rdr(1'b1, q); chk("R1 config reset", {32'd0, q}, 64'd0);
    chk("R1 mdc and oe reset", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;

    wr(1'b1, 32'hFFFFFFFF);
    rdr(1'b1, q); chk("R2 config fields", {32'd0, q}, 64'h0000_2FF1);
    wr(1'b1, 32'h0000_0011);
    bad = 0;
    repeat (40) begin @(negedge clk); if (mdc) bad++; end
    chk("R10 parked mdc", 64'(bad), 64'd0);

    run_cmd(1'b1, 2'd1, 5'd5, 5'h1A, 16'hA5C3, 1'b0, 16'h0000, "R5 clause22 write result");
    run_cmd(1'b1, 2'd2, 5'h1F, 5'd3, 16'h0000, 1'b0, 16'h1234, "R6 clause22 read result");
    run_cmd(1'b1, 2'd2, 5'd9, 5'd4, 16'h5555, 1'b1, 16'h9999, "R7 missing turnaround");
    wr(1'b0, 32'd0);
    rdr(1'b0, q); chk("R8 zero write clears fail", {32'd0, q}, 64'd0);

    wr(1'b1, 32'h0000_2020);
    @(posedge mdc); t1 = $time;
    @(negedge mdc); t2 = $time;
    @(posedge mdc); t3 = $time;
    chk("R9 high half-period", 64'((t2 - t1) / 10), 64'd3);
    chk("R9 low half-period", 64'((t3 - t2) / 10), 64'd3);
    tog = 0; pm = mdc;
    repeat (60) begin @(negedge clk); if (mdc != pm) tog++; pm = mdc; end
    chk("R10 free-run toggles while idle", {63'd0, tog >= 19}, 64'd1);

    run_cmd(1'b0, 2'd0, 5'd2, 5'd1, 16'h0010, 1'b0, 16'h0000, "R11 clause45 address");
    run_cmd(1'b0, 2'd3, 5'd2, 5'd1, 16'h0010, 1'b0, 16'hBEEF, "R6 clause45 read");
    run_cmd(1'b0, 2'd2, 5'd2, 5'd1, 16'h0010, 1'b0, 16'h0042, "R11 clause45 read-increment");

    // R12: nonzero write while busy is ignored
    phy_ta = 1'b0;
    qw.push_back(exp_wire(1'b0, 2'd1, 5'd7, 5'd30, 16'h7777, 1'b0, 1'b0, 16'h0));
    qo.push_back({64{1'b1}});
    wr(1'b0, {2'b00, 1'b1, 1'b0, 2'd1, 5'd7, 5'd30, 16'h7777});
    repeat (100) @(negedge clk);
    wr(1'b0, {2'b00, 1'b1, 1'b0, 2'd3, 5'd1, 5'd1, 16'h1111});
    rdr(1'b0, q);
    chk("R12 fields kept while busy", {32'd0, q}, {32'd0, 2'b00, 1'b1, 1'b0, 2'd1, 5'd7, 5'd30, 16'h7777});
    wait_idle(q);
    chk("R12 frame completed as first issued", {32'd0, q}, {32'd0, 2'b00, 1'b0, 1'b0, 2'd1, 5'd7, 5'd30, 16'h7777});

    // R8: abort mid-frame without free-run
    wr(1'b1, 32'h0000_0001);
    wr(1'b0, {2'b00, 1'b1, 1'b0, 2'd1, 5'd3, 5'd3, 16'hCAFE});
    repeat (30) @(negedge clk);
    chk("R8 frame running before abort", {63'd0, mdio_oe}, 64'd1);
    wr(1'b0, 32'd0);
    rdr(1'b0, q); chk("R8 abort clears command", {32'd0, q}, 64'd0);
    chk("R8 abort releases line", {63'd0, mdio_oe}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R8 mdc stopped low", {63'd0, mdc}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule